// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulation Sequencer

This block recreates the three interrupt sources of a real-time clock (periodic, seconds-update and alarm) from a 32-bit counter that runs freely and a one-shot compare target. The block holds the compare target itself. When the counter reaches the target, the block moves the target forward by a tick delta. If the counter has already passed several ticks, the block keeps adding the delta, one addition per clock, until the target is ahead again. It counts the ticks that were missed and passes them to the periodic divider, so periodic interrupts stay in step after a stall.

The base tick rate is 64 per second, and `base_delta_i` gives it as a number of counter steps. A periodic rate of 2^k per second is selected with `freq_log2_i` = k, for k from 1 to 13. For rates up to 64, the tick stays at the base rate and a divider fires the periodic flag every 2^(6-k) ticks. For higher rates, the tick delta itself is shortened to one period of the requested rate. The time-of-day values and the alarm setting come from outside. Each processed tick compares them for a change of seconds and for an alarm match. Any raised source produces a one-cycle flag word together with an interrupt strobe.

Top module: `rtc_irq_emu`

## Requirements
- R1: When periodic mode is off, or k <= 6, the tick delta equals `base_delta_i`. Arming sets `target_o` to the sampled counter plus that delta.
- R2: With periodic mode on and k <= 6, the periodic flag fires once every 2^(6-k) processed ticks.
- R3: With periodic mode on and k > 6, the tick delta is `base_delta_i >> (k-6)` and the periodic flag fires on every processed tick.
- R4: A match (the signed 32-bit value counter minus target is not negative) starts catch-up. From that point the target gains one delta per clock, and `busy_o` stays high, until counter minus target is negative. No new match is taken while `busy_o` is high.
- R5: When periodic mode is on, the additions beyond the first (the missed ticks) are added to the periodic divider count together with the tick itself.
- R6: The update flag is raised on a tick whose seconds value differs from the one recorded at the previous tick. The first tick after update mode is enabled only records the seconds.
- R7: The alarm flag is raised on a tick where hours, minutes and seconds all equal the alarm setting.
- R8: Flag word layout: bit 4 is the update flag, bit 5 the alarm flag, bit 6 the periodic flag, bit 7 the interrupt-request bit, and bits 15:8 hold the value 1. The word and `irq_o` appear for exactly one cycle, two clocks after catch-up ends, and the word is zero at all other times.
- R9: With all three enables low, the channel is disarmed and no tick is processed. Raising any enable from that state arms the channel at the next clock.
- R10: The periodic divider restarts from zero each time it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 32 | Counter value that runs freely |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hour_i | input | 8 | Current hours |
| alarm_sec_i | input | 8 | Alarm seconds |
| alarm_min_i | input | 8 | Alarm minutes |
| alarm_hour_i | input | 8 | Alarm hours |
| pie_en_i | input | 1 | Periodic interrupt enable |
| aie_en_i | input | 1 | Alarm interrupt enable |
| uie_en_i | input | 1 | Seconds-update interrupt enable |
| freq_log2_i | input | 4 | Periodic rate exponent k (rate 2^k per second, 1..13) |
| base_delta_i | input | 32 | Counter steps per base tick (64 per second) |
| flags_o | output | 16 | Flag word, valid while irq_o is high |
| irq_o | output | 1 | One-cycle interrupt strobe |
| armed_o | output | 1 | Compare channel armed |
| busy_o | output | 1 | Catch-up in progress |
| target_o | output | 32 | Current compare target |

## Verification
The assertions assume the following about the inputs. The tick delta is never zero while the channel is armed. The rate exponent stays within 1..13 while periodic mode is on. The counter advances by less than one delta per clock, which is what allows catch-up to finish. The bench keeps the base delta at 512, so the shortest delta is 4 steps. It either holds the counter still and moves it only by explicit jumps, or advances it by one step per clock. It changes the rate exponent only while periodic mode is off.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int unsigned UF_BIT  = 4;
  localparam int unsigned AF_BIT  = 5;
  localparam int unsigned PF_BIT  = 6;
  localparam int unsigned IRQ_BIT = 7;
  localparam int unsigned CNT_LSB = 8;
endpackage

// File: rtl/rtc_tick_sched.sv
module rtc_tick_sched #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] delta_i,
  output logic             armed_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] target_o,
  output logic             tick_o,
  output logic [CNT_W-1:0] lost_o
);
  logic             armed_q, busy_q, tick_q;
  logic [CNT_W-1:0] target_q, lost_q, diff;
  logic             reached;

  assign diff    = count_i - target_q;
  assign reached = ~diff[CNT_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      busy_q   <= 1'b0;
      tick_q   <= 1'b0;
      target_q <= '0;
      lost_q   <= '0;
    end else begin
      tick_q <= 1'b0;
      if (!any_en_i) begin
        armed_q <= 1'b0;
        busy_q  <= 1'b0;
        lost_q  <= '0;
      end else if (!armed_q) begin
        armed_q  <= 1'b1;
        target_q <= count_i + delta_i;
      end else if (busy_q) begin
        if (reached) begin
          target_q <= target_q + delta_i;
          lost_q   <= lost_q + 1'b1;
        end else begin
          busy_q <= 1'b0;
          tick_q <= 1'b1;
        end
      end else if (reached) begin
        target_q <= target_q + delta_i;
        busy_q   <= 1'b1;
        lost_q   <= '0;
      end
    end
  end

  assign armed_o  = armed_q;
  assign busy_o   = busy_q;
  assign target_o = target_q;
  assign tick_o   = tick_q;
  assign lost_o   = lost_q;

  p_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_en_i && !armed_q) |=> (armed_q && target_q == $past(count_i + delta_i)));
  p_disarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en_i |=> (!armed_q && !busy_q && !tick_q));
  p_ahead_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> ($signed($past(count_i) - target_q) < 0));
  p_catchup_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && any_en_i && reached) |=> (target_q == $past(target_q + delta_i)));
  p_delta_nz_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (delta_i != '0));
endmodule

// File: rtl/rtc_pie_div.sv
module rtc_pie_div #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pie_en_i,
  input  logic             direct_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] lost_i,
  output logic             pf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum  = {1'b0, cnt_q} + {1'b0, lost_i} + (CNT_W+1)'(1);
  assign pf_o = tick_i && pie_en_i && (direct_i || sum >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!pie_en_i)           cnt_q <= '0;
    else if (tick_i) begin
      if (pf_o || direct_i)       cnt_q <= '0;
      else                        cnt_q <= sum[CNT_W-1:0];
    end
  end

  p_div_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o |=> (cnt_q == '0));
  p_div_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && $past(cnt_q) == cnt_q && pie_en_i) |=> (cnt_q == $past(cnt_q) || !pie_en_i || tick_i || cnt_q == '0));
endmodule

// File: rtl/rtc_time_events.sv
module rtc_time_events #(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              uie_en_i,
  input  logic              aie_en_i,
  input  logic [TIME_W-1:0] sec_i,
  input  logic [TIME_W-1:0] min_i,
  input  logic [TIME_W-1:0] hour_i,
  input  logic [TIME_W-1:0] alarm_sec_i,
  input  logic [TIME_W-1:0] alarm_min_i,
  input  logic [TIME_W-1:0] alarm_hour_i,
  output logic              uf_o,
  output logic              af_o
);
  logic [TIME_W-1:0] prev_sec_q;
  logic              prev_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sec_q   <= '0;
      prev_valid_q <= 1'b0;
    end else if (!uie_en_i) begin
      prev_valid_q <= 1'b0;
    end else if (tick_i) begin
      prev_sec_q   <= sec_i;
      prev_valid_q <= 1'b1;
    end
  end

  assign uf_o = tick_i && uie_en_i && prev_valid_q && (sec_i != prev_sec_q);
  assign af_o = tick_i && aie_en_i && (sec_i == alarm_sec_i) &&
                (min_i == alarm_min_i) && (hour_i == alarm_hour_i);

  // first tick after enabling only records the seconds
  p_uf_first_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uie_en_i |=> !uf_o);
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rtc_emu_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned TIME_W    = 8,
  parameter int unsigned FREQ_W    = 4,
  parameter int unsigned FLAG_W    = 16,
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned MAX_LOG2  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [TIME_W-1:0] sec_i,
  input  logic [TIME_W-1:0] min_i,
  input  logic [TIME_W-1:0] hour_i,
  input  logic [TIME_W-1:0] alarm_sec_i,
  input  logic [TIME_W-1:0] alarm_min_i,
  input  logic [TIME_W-1:0] alarm_hour_i,
  input  logic              pie_en_i,
  input  logic              aie_en_i,
  input  logic              uie_en_i,
  input  logic [FREQ_W-1:0] freq_log2_i,
  input  logic [CNT_W-1:0]  base_delta_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic              armed_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  target_o
);
  localparam logic [FREQ_W-1:0] BASE_K = FREQ_W'(BASE_LOG2);
  localparam int unsigned       CW     = FLAG_W - CNT_LSB;

  logic              any_en, direct, tick, pf, uf, af, hit;
  logic [FREQ_W-1:0] sh_up, sh_dn;
  logic [CNT_W-1:0]  delta, limit, lost;
  logic [FLAG_W-1:0] word, flags_q;
  logic              irq_q;

  assign any_en = pie_en_i | aie_en_i | uie_en_i;
  assign direct = pie_en_i && (freq_log2_i > BASE_K);
  assign sh_up  = freq_log2_i - BASE_K;
  assign sh_dn  = BASE_K - freq_log2_i;
  assign delta  = direct ? (base_delta_i >> sh_up) : base_delta_i;
  assign limit  = direct ? CNT_W'(1) : (CNT_W'(1) << sh_dn);

  rtc_tick_sched #(.CNT_W(CNT_W)) i_sched (
    .clk_i, .rst_ni,
    .any_en_i (any_en),
    .count_i,
    .delta_i  (delta),
    .armed_o,
    .busy_o,
    .target_o,
    .tick_o   (tick),
    .lost_o   (lost)
  );

  rtc_pie_div #(.CNT_W(CNT_W)) i_div (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .pie_en_i,
    .direct_i (direct),
    .limit_i  (limit),
    .lost_i   (lost),
    .pf_o     (pf)
  );

  rtc_time_events #(.TIME_W(TIME_W)) i_evt (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .uie_en_i, .aie_en_i,
    .sec_i, .min_i, .hour_i,
    .alarm_sec_i, .alarm_min_i, .alarm_hour_i,
    .uf_o     (uf),
    .af_o     (af)
  );

  assign hit = pf | af | uf;

  always_comb begin
    word                  = '0;
    word[FLAG_W-1:CNT_LSB] = CW'(1);
    word[IRQ_BIT]         = 1'b1;
    word[PF_BIT]          = pf;
    word[AF_BIT]          = af;
    word[UF_BIT]          = uf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= hit ? word : '0;
      irq_q   <= hit;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_word_layout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o[IRQ_BIT] && flags_o[FLAG_W-1:CNT_LSB] == CW'(1)));
  p_word_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (flags_o == '0));
  p_irq_after_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick));
  p_freq_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pie_en_i |-> (freq_log2_i >= FREQ_W'(1) && freq_log2_i <= FREQ_W'(MAX_LOG2)));
endmodule

// File: tb/test_rtc_irq_emu.sv
module test_rtc_irq_emu;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'd512;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] count = 32'd1000;
  logic [7:0]  sec = 0, min = 0, hour = 0, a_sec = 0, a_min = 0, a_hour = 0;
  logic        pie = 0, aie = 0, uie = 0;
  logic [3:0]  freq = 4'd1;
  logic [15:0] flags_o;
  logic        irq_o, armed_o, busy_o;
  logic [31:0] target_o;

  logic        cnt_run = 0;
  int          cyc = 0;
  int          errs = 0, total = 0;
  logic [31:0] exp_tgt, exp_delta;

  rtc_irq_emu i_rtc_irq_emu (
    .clk_i(clk), .rst_ni(rst_ni), .count_i(count),
    .sec_i(sec), .min_i(min), .hour_i(hour),
    .alarm_sec_i(a_sec), .alarm_min_i(a_min), .alarm_hour_i(a_hour),
    .pie_en_i(pie), .aie_en_i(aie), .uie_en_i(uie),
    .freq_log2_i(freq), .base_delta_i(BASE),
    .flags_o(flags_o), .irq_o(irq_o), .armed_o(armed_o),
    .busy_o(busy_o), .target_o(target_o)
  );

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    if (cnt_run) count = count + 1;
  end

  function automatic logic [15:0] fword(input logic p, input logic a, input logic u);
    return 16'h0100 | 16'h0080 | (16'(p) << 6) | (16'(a) << 5) | (16'(u) << 4);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic mtick(output logic seen, output logic [15:0] fl, output int n);
    seen = 0; fl = 0; n = 0;
    count = exp_tgt;
    exp_tgt = exp_tgt + exp_delta;
    repeat (6) begin
      @(negedge clk);
      if (irq_o) begin seen = 1; fl = flags_o; n++; end
    end
  endtask

  task automatic wait_irq(input int lim, output logic ok, output int t, output logic [15:0] fl);
    int i = 0;
    ok = 0; t = 0; fl = 0;
    while (!ok && i < lim) begin
      @(negedge clk);
      if (irq_o) begin ok = 1; t = cyc; fl = flags_o; end
      i++;
    end
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    logic        seen, ok1, ok2;
    logic [15:0] fl, fl2;
    int          n, t1, t2, busy_n, irq_n;
    logic [31:0] c, d, per;

    repeat (3) @(negedge clk);
    check(flags_o == 0 && !irq_o, "R8 reset quiet", {15'd0, irq_o, flags_o}, 0);
    check(!armed_o && !busy_o, "R9 reset disarmed", {30'd0, armed_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: base delta with update mode only, high rate code ignored
    freq = 4'd13; uie = 1; sec = 10;
    @(negedge clk);
    check(armed_o && target_o == 32'd1512, "R1 arm base delta", target_o, 32'd1512);
    exp_tgt = 32'd1512; exp_delta = BASE;

    // R6: first tick records only
    mtick(seen, fl, n);
    check(!seen, "R6 first tick silent", {31'd0, seen}, 0);
    check(target_o == exp_tgt, "R4 single step target", target_o, exp_tgt);
    mtick(seen, fl, n);
    check(!seen, "R6 same second silent", {31'd0, seen}, 0);
    sec = 11;
    mtick(seen, fl, n);
    check(seen && fl == fword(0, 0, 1), "R6 R8 update word", {16'd0, fl}, {16'd0, fword(0, 0, 1)});
    check(n == 1, "R8 strobe one cycle", n, 1);

    // R7 alarm
    aie = 1; a_hour = 1; a_min = 2; a_sec = 3; hour = 1; min = 2;
    mtick(seen, fl, n);
    check(!seen, "R7 alarm mismatch", {31'd0, seen}, 0);
    sec = 3;
    mtick(seen, fl, n);
    check(seen && fl == fword(0, 1, 1), "R7 R8 alarm plus update", {16'd0, fl}, {16'd0, fword(0, 1, 1)});
    hour = 5;
    mtick(seen, fl, n);
    check(!seen, "R7 hour mismatch", {31'd0, seen}, 0);

    // R9 disable
    uie = 0; aie = 0;
    @(negedge clk);
    check(!armed_o, "R9 disarm", {31'd0, armed_o}, 0);
    count = exp_tgt;
    irq_n = 0;
    repeat (6) begin @(negedge clk); if (irq_o || busy_o) irq_n++; end
    check(irq_n == 0, "R9 no tick while disabled", irq_n, 0);

    // R9 rearm, R6 record again
    count = 32'd5000; uie = 1; sec = 20;
    @(negedge clk);
    check(armed_o && target_o == 32'd5512, "R9 rearm target", target_o, 32'd5512);
    exp_tgt = 32'd5512;
    mtick(seen, fl, n);
    check(!seen, "R6 record after re-enable", {31'd0, seen}, 0);

    // R4 R5 catch-up with divider of 16
    uie = 0;
    @(negedge clk);
    count = 32'd10000; freq = 4'd2; pie = 1;
    @(negedge clk);
    check(target_o == 32'd10512, "R1 low rate keeps base delta", target_o, 32'd10512);
    count = 32'd10512 + 3 * BASE + 10;
    busy_n = 0; irq_n = 0;
    repeat (10) begin @(negedge clk); if (busy_o) busy_n++; if (irq_o) irq_n++; end
    check(busy_n == 4, "R4 catch-up cycles", busy_n, 4);
    check(target_o == 32'd10512 + 4 * BASE, "R4 target ahead", target_o, 32'd10512 + 4 * BASE);
    check(irq_n == 0, "R5 no flag yet", irq_n, 0);
    exp_tgt = 32'd10512 + 4 * BASE;
    irq_n = 0;
    for (int i = 0; i < 11; i++) begin mtick(seen, fl, n); if (seen) irq_n++; end
    check(irq_n == 0, "R5 lost ticks counted", irq_n, 0);
    mtick(seen, fl, n);
    check(seen && fl == fword(1, 0, 0), "R5 R2 periodic after 12", {16'd0, fl}, {16'd0, fword(1, 0, 0)});
    irq_n = 0;
    for (int i = 0; i < 15; i++) begin mtick(seen, fl, n); if (seen) irq_n++; end
    check(irq_n == 0, "R10 restart from zero", irq_n, 0);
    mtick(seen, fl, n);
    check(seen && fl == fword(1, 0, 0), "R10 fires after full count", {16'd0, fl}, {16'd0, fword(1, 0, 0)});

    // sweep all rate codes with counter running
    for (int k = 1; k <= 13; k++) begin
      pie = 0; freq = 4'(k);
      @(negedge clk);
      c = count; pie = 1;
      d = (k > 6) ? (BASE >> (k - 6)) : BASE;
      per = (k > 6) ? d : (BASE << (6 - k));
      @(negedge clk);
      check(target_o == c + d, (k > 6) ? "R3 direct delta" : "R1 base delta sweep", target_o, c + d);
      cnt_run = 1;
      wait_irq(int'(per) + 64, ok1, t1, fl);
      wait_irq(int'(per) + 64, ok2, t2, fl2);
      cnt_run = 0;
      check(ok1 && ok2 && fl2 == fword(1, 0, 0), "R2 R3 periodic word", {16'd0, fl2}, {16'd0, fword(1, 0, 0)});
      check(ok1 && ok2 && (t2 - t1) == int'(per), (k > 6) ? "R3 period" : "R2 period", t2 - t1, per);
    end
    pie = 0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule